// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block keeps the pending-interrupt flags of two timer/counters in one 8-bit status register. Single-cycle event strobes from the timer datapaths set the flags: timer-1 overflow, compare match A, compare match B, input capture and timer-0 overflow. Software clears a flag by writing a one to its bit. The interrupt vectoring logic clears a flag by pulsing that source's acknowledge strobe when the matching vector is taken.

Each source raises its own interrupt request. A request is high only while the global enable, the source's enable bit and the source's flag are all set. When timer-1 runs in PWM mode, its overflow flag follows the strobe that marks the counting-direction reversal at zero, and the plain wraparound strobe is ignored.

All pins are plain control and status signals. No data stream flows through the block, so there is no valid/ready handshake. The register port is a single-cycle select/write/read port with no back-pressure.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, every register bit is zero and every request output is low.
- R2: Each event strobe sets its flag, which reads back from the next cycle on. The bit positions are: timer-1 overflow at bit 7, compare A at bit 6, compare B at bit 5, capture at bit 3, and timer-0 overflow at bit 1.
- R3: Bits 0, 2 and 4 always read zero, and writes to them change nothing.
- R4: A write (`reg_sel` and `wr_en` high) with a one in a flag's bit clears that flag at the next edge. A zero in that bit leaves the flag unchanged.
- R5: A pulse on `ack[i]` clears flag i at the next edge. The source index order is 0 timer-1 overflow, 1 compare A, 2 compare B, 3 capture, 4 timer-0 overflow.
- R6: `irq[i]` equals `gie & src_en[i] & flag i`, combinationally, using the same index order as R5.
- R7: While `pwm_mode` is high, the timer-1 overflow flag is set by `ev_t1_turn` and `ev_t1_wrap` is ignored. While `pwm_mode` is low, the reverse holds.
- R8: When a set event and a clear (a write of one or an acknowledge) hit the same flag in the same cycle, the flag is one afterwards.
- R9: `rd_data` is zero while `reg_sel` is low. Reading has no side effects on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_t1_wrap | input | 1 | Timer-1 wraparound strobe |
| ev_t1_turn | input | 1 | Timer-1 direction reversal at zero strobe |
| pwm_mode | input | 1 | Timer-1 runs in PWM mode |
| ev_cmp_a | input | 1 | Compare A match strobe |
| ev_cmp_b | input | 1 | Compare B match strobe |
| ev_capture | input | 1 | Input capture strobe |
| ev_t0_wrap | input | 1 | Timer-0 wraparound strobe |
| reg_sel | input | 1 | Register address match |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data, ones clear flags |
| rd_data | output | 8 | Register read value |
| src_en | input | 5 | Per-source interrupt enables |
| gie | input | 1 | Global interrupt enable |
| ack | input | 5 | Per-source vector-taken strobes |
| irq | output | 5 | Per-source interrupt requests |

## Verification
The bench builds the block with its default parameters: an 8-bit register and five sources. These defaults place every flag position and every reserved position within reach of a directed write. Same-cycle collisions of set events with write-one and acknowledge clears are driven directly. The PWM selector is exercised in both modes, so that the ignored overflow strobe of each mode can be seen at the register.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int REG_W = 8;
  localparam int N_SRC = 5;
  // register bit of each source, index order is the vectoring order
  localparam int SRC_BIT [N_SRC] = '{7, 6, 5, 3, 1};
  typedef enum logic [2:0] {
    SRC_T1_OVF = 3'd0,
    SRC_CMP_A  = 3'd1,
    SRC_CMP_B  = 3'd2,
    SRC_CAP    = 3'd3,
    SRC_T0_OVF = 3'd4
  } src_e;
endpackage

// File: rtl/tmr_flag_cell.sv
module tmr_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // set beats a same-cycle clear
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/tmr_ovf_sel.sv
module tmr_ovf_sel (
  input  logic pwm_mode,
  input  logic wrap_i,
  input  logic turn_i,
  output logic set_o
);
  always_comb set_o = pwm_mode ? turn_i : wrap_i;
endmodule

// File: rtl/tmr_reg_pack.sv
module tmr_reg_pack #(
  parameter int REG_W = tmr_irq_pkg::REG_W,
  parameter int N_SRC = tmr_irq_pkg::N_SRC
) (
  input  logic [N_SRC-1:0] flag_i,
  input  logic             sel_i,
  output logic [REG_W-1:0] rd_o
);
  logic [REG_W-1:0] packed_v;
  always_comb begin
    packed_v = '0;
    for (int i = 0; i < N_SRC; i++)
      packed_v[tmr_irq_pkg::SRC_BIT[i]] = flag_i[i];
    rd_o = sel_i ? packed_v : '0;
  end
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int REG_W = tmr_irq_pkg::REG_W,
  parameter int N_SRC = tmr_irq_pkg::N_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_t1_wrap,
  input  logic             ev_t1_turn,
  input  logic             pwm_mode,
  input  logic             ev_cmp_a,
  input  logic             ev_cmp_b,
  input  logic             ev_capture,
  input  logic             ev_t0_wrap,
  input  logic             reg_sel,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [N_SRC-1:0] src_en,
  input  logic             gie,
  input  logic [N_SRC-1:0] ack,
  output logic [N_SRC-1:0] irq
);
  import tmr_irq_pkg::*;

  logic             t1_set;
  logic [N_SRC-1:0] set_vec;
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] flag_q;
  logic             wr_hit;

  tmr_ovf_sel u_ovf_sel (
    .pwm_mode (pwm_mode),
    .wrap_i   (ev_t1_wrap),
    .turn_i   (ev_t1_turn),
    .set_o    (t1_set)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[SRC_T1_OVF] = t1_set;
    set_vec[SRC_CMP_A]  = ev_cmp_a;
    set_vec[SRC_CMP_B]  = ev_cmp_b;
    set_vec[SRC_CAP]    = ev_capture;
    set_vec[SRC_T0_OVF] = ev_t0_wrap;
  end

  assign wr_hit = reg_sel & wr_en;

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    assign clr_vec[i] = (wr_hit & wr_data[SRC_BIT[i]]) | ack[i];
    tmr_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[i]),
      .clr_i (clr_vec[i]),
      .q_o   (flag_q[i])
    );
  end

  tmr_reg_pack #(.REG_W(REG_W), .N_SRC(N_SRC)) u_pack (
    .flag_i (flag_q),
    .sel_i  (reg_sel),
    .rd_o   (rd_data)
  );

  assign irq = flag_q & src_en & {N_SRC{gie}};
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_mode,
  input logic       ev_t1_wrap,
  input logic       ev_t1_turn,
  input logic       ev_cmp_a,
  input logic       reg_sel,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [4:0] ack,
  input logic       gie,
  input logic [4:0] irq,
  input logic [4:0] flag_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (flag_q == 5'b0));
  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & 8'h15) == 8'h00);
  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && wr_en && wr_data[6] && !ev_cmp_a) |=> !flag_q[1]);
  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[1] && !ev_cmp_a) |=> !flag_q[1]);
  // R6
  irq_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq) |-> gie);
  // R7
  pwm_wrap_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && ev_t1_wrap && !ev_t1_turn && !flag_q[0]) |=> !flag_q[0]);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmp_a |=> flag_q[1]);
  // R9
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |-> (rd_data == 8'h00));
endmodule

bind tmr_irq_flags tmr_irq_flags_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwm_mode   (pwm_mode),
  .ev_t1_wrap (ev_t1_wrap),
  .ev_t1_turn (ev_t1_turn),
  .ev_cmp_a   (ev_cmp_a),
  .reg_sel    (reg_sel),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .ack        (ack),
  .gie        (gie),
  .irq        (irq),
  .flag_q     (flag_q)
);

// File: tb/sim_tmr_irq_flags.sv
module sim_tmr_irq_flags;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] evs = '0;         // 0 t1 wrap, 1 cmp A, 2 cmp B, 3 capture, 4 t0 wrap
  logic       ev_t1_turn = 1'b0;
  logic       pwm_mode = 1'b0;
  logic       reg_sel = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [4:0] src_en = '0;
  logic       gie = 1'b0;
  logic [4:0] ack = '0;
  logic [4:0] irq;
  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_irq_flags u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_t1_wrap(evs[0]), .ev_t1_turn(ev_t1_turn), .pwm_mode(pwm_mode),
    .ev_cmp_a(evs[1]), .ev_cmp_b(evs[2]), .ev_capture(evs[3]), .ev_t0_wrap(evs[4]),
    .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .src_en(src_en), .gie(gie), .ack(ack), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // one clock: inputs were applied at a falling edge, strobes drop at the next one
  task automatic step();
    @(negedge clk);
    evs = '0; ev_t1_turn = 1'b0; wr_en = 1'b0; wr_data = '0; ack = '0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    evs = 5'h1f; src_en = 5'h1f; gie = 1'b1;
    step();
    do_reset();
    check("R1 flags after reset", rd_data, 8'h00);
    check("R1 irq after reset", {3'b0, irq}, 8'h00);
    gie = 1'b0; src_en = '0;
  endtask

  task automatic t_set_each();
    logic [7:0] pos [5] = '{8'h80, 8'h40, 8'h20, 8'h08, 8'h02};
    for (int i = 0; i < 5; i++) begin
      do_reset();
      evs = 5'b1 << i;
      step();
      check($sformatf("R2 source %0d bit", i), rd_data, pos[i]);
    end
    do_reset();
    evs = 5'h1f;
    step();
    check("R2 all sources", rd_data, 8'hEA);
  endtask

  task automatic t_reserved();
    do_reset();
    wr_en = 1'b1; wr_data = 8'hFF;
    step();
    check("R3 write ones to reserved", rd_data, 8'h00);
    evs = 5'h1f;
    step();
    wr_en = 1'b1; wr_data = 8'h15;
    step();
    check("R3 reserved write keeps flags", rd_data, 8'hEA);
  endtask

  task automatic t_w1c();
    do_reset();
    evs = 5'h1f;
    step();
    wr_en = 1'b1; wr_data = 8'h00;
    step();
    check("R4 write zero no change", rd_data, 8'hEA);
    wr_en = 1'b1; wr_data = 8'h48;
    step();
    check("R4 write one clears cmpA/capture", rd_data, 8'hA2);
    reg_sel = 1'b0; wr_en = 1'b1; wr_data = 8'hFF;
    step();
    reg_sel = 1'b1; #1;
    check("R4 write without select ignored", rd_data, 8'hA2);
  endtask

  task automatic t_ack();
    do_reset();
    evs = 5'h1f;
    step();
    ack = 5'b10001;
    step();
    check("R5 ack clears t1/t0 overflow", rd_data, 8'h68);
    ack = 5'b00100;
    step();
    check("R5 ack clears cmpB", rd_data, 8'h48);
  endtask

  task automatic t_irq();
    do_reset();
    evs = 5'h1f;
    step();
    src_en = 5'b10101; gie = 1'b1; #1;
    check("R6 irq masked by enables", {3'b0, irq}, 8'h15);
    gie = 1'b0; #1;
    check("R6 irq off without gie", {3'b0, irq}, 8'h00);
    gie = 1'b1; wr_en = 1'b1; wr_data = 8'h80;
    step();
    check("R6 irq drops after clear", {3'b0, irq}, 8'h14);
    gie = 1'b0; src_en = '0;
  endtask

  task automatic t_pwm();
    do_reset();
    pwm_mode = 1'b1; evs = 5'b00001;
    step();
    check("R7 wrap ignored in pwm", rd_data, 8'h00);
    ev_t1_turn = 1'b1;
    step();
    check("R7 turn sets in pwm", rd_data, 8'h80);
    do_reset();
    pwm_mode = 1'b0; ev_t1_turn = 1'b1;
    step();
    check("R7 turn ignored outside pwm", rd_data, 8'h00);
  endtask

  task automatic t_collision();
    do_reset();
    evs = 5'b00010; wr_en = 1'b1; wr_data = 8'h40;
    step();
    check("R8 set beats write clear", rd_data, 8'h40);
    evs = 5'b01000; ack = 5'b01000;
    step();
    check("R8 set beats ack", rd_data, 8'h48);
  endtask

  task automatic t_read();
    do_reset();
    evs = 5'b00100;
    step();
    reg_sel = 1'b0; #1;
    check("R9 unselected read zero", rd_data, 8'h00);
    reg_sel = 1'b1;
    repeat (3) step();
    check("R9 repeated reads keep flag", rd_data, 8'h20);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_set_each();
    t_reserved();
    t_w1c();
    t_ack();
    t_irq();
    t_pwm();
    t_collision();
    t_read();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule